// File: doc/BRIEF.md
# Cartridge Bank Controller

This block sits between an 8-bit CPU bus and the memories of a plug-in cartridge. The cartridge ROM is read-only, so CPU writes into the lower 32 KiB of the address map are taken as commands instead. Each command writes one of four small registers: a RAM gate, a five-bit low ROM bank field, a two-bit shared field and a mode bit. The mode bit decides whether the shared field selects the external RAM bank or supplies the two top bits of the ROM bank.

The controller turns the CPU address into a physical ROM address and a physical RAM address. The first 16 KiB of ROM is always bank 0. The second 16 KiB window shows the selected bank. The 8 KiB external RAM window at 0xA000–0xBFFF shows the selected RAM bank. The controller also gates RAM writes and muxes the read data that goes back to the CPU. A command write changes the registers at the clock edge that ends its cycle. Address translation is combinational and uses the register values from before that edge.

Top module: `bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1 (bits 6:5 zero, bits 4:0 equal 1), the RAM bank is 0, the mode is 0 and the RAM gate is closed.
- R2: A write to 0x0000–0x1FFF opens the RAM gate when data bits 3:0 equal 0xA. Any other value closes it. The gate state is driven on `ram_on`.
- R3: A write to 0x2000–0x3FFF loads data bits 4:0 into ROM bank bits 4:0, and a value of 0 is stored as 1. ROM bank bits 6:5 are unchanged.
- R4: A write to 0x4000–0x5FFF while the mode is 1 loads data bits 1:0 into the RAM bank and leaves the ROM bank unchanged.
- R5: A write to 0x4000–0x5FFF while the mode is 0 loads data bits 1:0 into ROM bank bits 6:5. It leaves ROM bank bits 4:0 and the RAM bank unchanged.
- R6: A write to 0x6000–0x7FFF loads data bit 0 into the mode. No other write changes the mode.
- R7: For an address in 0x0000–0x3FFF, `rom_addr` equals address bits 13:0, and its upper bits are zero.
- R8: For an address in 0x4000–0x7FFF, `rom_addr` equals ROM bank × 0x4000 + address bits 13:0.
- R9: For an address in 0xA000–0xBFFF, `ram_addr` equals RAM bank × 0x2000 + address bits 12:0.
- R10: `ram_we` is high only for a write into 0xA000–0xBFFF while the gate is open. `cpu_rdata` returns `rom_rdata` for addresses below 0x8000. It returns `ram_rdata` in the RAM window while the gate is open. It returns 0xFF in the RAM window while the gate is closed, and everywhere else.
- R11: A register write takes effect from the next cycle. In the cycle of the write itself, the translated addresses still use the old register values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe for the current cycle |
| rom_rdata | input | 8 | Data returned by the ROM array |
| ram_rdata | input | 8 | Data returned by the RAM array |
| rom_addr | output | 21 | Physical ROM address |
| ram_addr | output | 15 | Physical RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_on | output | 1 | RAM gate state |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
A command write always targets the switchable ROM window or the fixed window. Its address is therefore translated in the same cycle that it changes the bank registers. A write to 0x4000–0x7FFF can move the ROM bank while `rom_addr` for that same address is on the output. The bench provokes this with directed shared-field writes, and with random writes in which the address is held for the following read. Each result is judged against a model that applies writes only after the edge: the cycle of the write must show the old bank, and the next cycle must show the new one.

// File: rtl/bank_ctrl_pkg.sv
package bank_ctrl_pkg;

  // Region decoded from the three top address bits
  typedef enum logic [2:0] {
    RG_GATE   = 3'd0,
    RG_LOBANK = 3'd1,
    RG_SHARED = 3'd2,
    RG_MODE   = 3'd3,
    RG_VIDEO  = 3'd4,
    RG_XRAM   = 3'd5,
    RG_WORK   = 3'd6,
    RG_HIGH   = 3'd7
  } region_e;

  function automatic region_e region_of(input logic [2:0] top3);
    return region_e'(top3);
  endfunction

endpackage

// File: rtl/bank_regs.sv
module bank_regs
  import bank_ctrl_pkg::*;
#(
  parameter int LO_W   = 5,
  parameter int HI_W   = 2,
  parameter int KEY_W  = 4,
  parameter logic [KEY_W-1:0] GATE_KEY = 4'hA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  region_e              region,
  input  logic [LO_W-1:0]      wd_lo,
  input  logic [KEY_W-1:0]     wd_key,
  output logic                 gate_q,
  output logic                 mode_q,
  output logic [LO_W+HI_W-1:0] rom_bank_q,
  output logic [HI_W-1:0]      ram_bank_q,
  output logic                 ev_gate,
  output logic                 ev_lobank,
  output logic                 ev_shared,
  output logic                 ev_mode
);
  localparam int BANK_W = LO_W + HI_W;

  // A zero low-bank value is stored as one
  function automatic logic [LO_W-1:0] coerce_low(input logic [LO_W-1:0] v);
    return (v == '0) ? LO_W'(1) : v;
  endfunction

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;

  assign ev_gate   = wr && (region == RG_GATE);
  assign ev_lobank = wr && (region == RG_LOBANK);
  assign ev_shared = wr && (region == RG_SHARED);
  assign ev_mode   = wr && (region == RG_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q     <= 1'b0;
      mode_q     <= 1'b0;
      lo_q       <= LO_W'(1);
      hi_q       <= '0;
      ram_bank_q <= '0;
    end else begin
      if (ev_gate)   gate_q <= (wd_key == GATE_KEY);
      if (ev_lobank) lo_q   <= coerce_low(wd_lo);
      if (ev_shared) begin
        if (mode_q) ram_bank_q <= wd_lo[HI_W-1:0];
        else        hi_q       <= wd_lo[HI_W-1:0];
      end
      if (ev_mode)   mode_q <= wd_lo[0];
    end
  end

  assign rom_bank_q = BANK_W'({hi_q, lo_q});

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 7,
  parameter int HI_W      = 2,
  parameter int ROM_WIN_W = 14,
  parameter int RAM_WIN_W = 13
) (
  input  logic [ADDR_W-1:0]           addr,
  input  region_e                     region,
  input  logic                        wr,
  input  logic                        gate,
  input  logic [BANK_W-1:0]           rom_bank,
  input  logic [HI_W-1:0]             ram_bank,
  input  logic [DATA_W-1:0]           rom_rdata,
  input  logic [DATA_W-1:0]           ram_rdata,
  output logic [BANK_W+ROM_WIN_W-1:0] rom_addr,
  output logic [HI_W+RAM_WIN_W-1:0]   ram_addr,
  output logic                        ram_we,
  output logic [DATA_W-1:0]           cpu_rdata
);
  localparam int ROM_AW = BANK_W + ROM_WIN_W;
  localparam int RAM_AW = HI_W + RAM_WIN_W;

  function automatic logic [ROM_AW-1:0] rom_phys(input logic [BANK_W-1:0] bank,
                                                 input logic [ROM_WIN_W-1:0] off,
                                                 input logic switched);
    logic [BANK_W-1:0] b;
    b = switched ? bank : '0;
    return {b, off};
  endfunction

  function automatic logic [RAM_AW-1:0] ram_phys(input logic [HI_W-1:0] bank,
                                                 input logic [RAM_WIN_W-1:0] off);
    return {bank, off};
  endfunction

  logic rom_sel, ram_sel;
  assign rom_sel = !addr[ADDR_W-1];
  assign ram_sel = (region == RG_XRAM);

  assign rom_addr = rom_phys(rom_bank, addr[ROM_WIN_W-1:0], addr[ROM_WIN_W]);
  assign ram_addr = ram_phys(ram_bank, addr[RAM_WIN_W-1:0]);
  assign ram_we   = wr && ram_sel && gate;

  always_comb begin
    if (rom_sel)            cpu_rdata = rom_rdata;
    else if (ram_sel && gate) cpu_rdata = ram_rdata;
    else                    cpu_rdata = '1;
  end

endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LO_W      = 5,
  parameter int HI_W      = 2,
  parameter int ROM_WIN_W = 14,
  parameter int RAM_WIN_W = 13,
  parameter int BANK_W    = LO_W + HI_W,
  parameter int ROM_AW    = BANK_W + ROM_WIN_W,
  parameter int RAM_AW    = HI_W + RAM_WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic              ram_on,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam int KEY_W = 4;

  region_e           region;
  logic              mode_q;
  logic [BANK_W-1:0] rom_bank_q;
  logic [HI_W-1:0]   ram_bank_q;
  logic              ev_gate, ev_lobank, ev_shared, ev_mode;
  logic              unused_wdata;

  assign region       = region_of(cpu_addr[ADDR_W-1 -: 3]);
  assign unused_wdata = ^cpu_wdata[DATA_W-1:LO_W];

  bank_regs #(
    .LO_W(LO_W), .HI_W(HI_W), .KEY_W(KEY_W), .GATE_KEY(4'hA)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .region(region),
    .wd_lo(cpu_wdata[LO_W-1:0]), .wd_key(cpu_wdata[KEY_W-1:0]),
    .gate_q(ram_on), .mode_q(mode_q), .rom_bank_q(rom_bank_q),
    .ram_bank_q(ram_bank_q), .ev_gate(ev_gate), .ev_lobank(ev_lobank),
    .ev_shared(ev_shared), .ev_mode(ev_mode)
  );

  bank_xlate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .HI_W(HI_W),
    .ROM_WIN_W(ROM_WIN_W), .RAM_WIN_W(RAM_WIN_W)
  ) u_xlate (
    .addr(cpu_addr), .region(region), .wr(cpu_wr), .gate(ram_on),
    .rom_bank(rom_bank_q), .ram_bank(ram_bank_q),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_we(ram_we),
    .cpu_rdata(cpu_rdata)
  );

endmodule

// File: rtl/bank_ctrl_chk.sv
module bank_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LO_W   = 5,
  parameter int HI_W   = 2,
  parameter int BANK_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_wr,
  input logic              ram_we,
  input logic              ram_on,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              mode_q,
  input logic [BANK_W-1:0] rom_bank_q,
  input logic [HI_W-1:0]   ram_bank_q,
  input logic              ev_gate,
  input logic              ev_lobank,
  input logic              ev_shared,
  input logic              ev_mode
);
  p_gate_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_gate |=> ram_on == ($past(cpu_wdata[3:0]) == 4'hA));

  p_low_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lobank |=> (rom_bank_q[LO_W-1:0] != '0) &&
                  (rom_bank_q[BANK_W-1:LO_W] == $past(rom_bank_q[BANK_W-1:LO_W])));

  p_shared_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_shared && mode_q) |=> (ram_bank_q == $past(cpu_wdata[HI_W-1:0])) && $stable(rom_bank_q));

  p_shared_rom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_shared && !mode_q) |=> (rom_bank_q[BANK_W-1:LO_W] == $past(cpu_wdata[HI_W-1:0])) &&
                               $stable(ram_bank_q));

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_mode |=> $stable(mode_q));

  p_we_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_on && cpu_wr));

  p_closed_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1 -: 3] == 3'b101 && !ram_on) |-> cpu_rdata == '1);

endmodule

bind bank_ctrl bank_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LO_W(LO_W), .HI_W(HI_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .ram_we(ram_we), .ram_on(ram_on), .cpu_rdata(cpu_rdata),
  .mode_q(mode_q), .rom_bank_q(rom_bank_q), .ram_bank_q(ram_bank_q),
  .ev_gate(ev_gate), .ev_lobank(ev_lobank), .ev_shared(ev_shared), .ev_mode(ev_mode)
);

// File: tb/sim_bank_ctrl.sv
`timescale 1ns/1ps
module sim_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  rom_rdata = '0;
  logic [7:0]  ram_rdata = '0;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_we, ram_on;
  logic [7:0]  cpu_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  int m_bank = 1, m_rb = 0, m_mode = 0, m_on = 0;

  always #2 clk = ~clk;

  bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_on(ram_on), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rom(input int a);
    if ((a & 32'h4000) != 0) return m_bank * 32'h4000 + (a & 32'h3FFF);
    return a & 32'h3FFF;
  endfunction

  function automatic int exp_ram(input int a);
    return m_rb * 32'h2000 + (a & 32'h1FFF);
  endfunction

  function automatic bit in_xram(input int a);
    return (a >= 32'hA000) && (a < 32'hC000);
  endfunction

  task automatic model_write(input int a, input int d);
    int lo;
    if (a < 32'h2000) m_on = ((d & 15) == 10);
    else if (a < 32'h4000) begin
      lo = d & 32'h1F;
      if (lo == 0) lo = 1;
      m_bank = (m_bank & 32'h60) | lo;
    end else if (a < 32'h6000) begin
      if (m_mode != 0) m_rb = d & 3;
      else m_bank = (m_bank & 32'h1F) | ((d & 3) << 5);
    end else if (a < 32'h8000) m_mode = d & 1;
  endtask

  task automatic drive(input int a, input int d, input bit w);
    @(negedge clk);
    cpu_addr  = a[15:0];
    cpu_wdata = d[7:0];
    cpu_wr    = w;
    rom_rdata = 8'($urandom);
    ram_rdata = 8'($urandom);
    #1;
  endtask

  task automatic commit(input int a, input int d, input bit w);
    @(posedge clk);
    if (w) model_write(a, d);
  endtask

  task automatic check_all(input int a, input bit w);
    int exp_rd;
    if (a < 32'h8000) chk((a & 32'h4000) != 0 ? "R8 rom_addr" : "R7 rom_addr", int'(rom_addr), exp_rom(a));
    if (in_xram(a)) chk("R9 ram_addr", int'(ram_addr), exp_ram(a));
    chk("R2 ram_on", int'(ram_on), m_on);
    chk("R10 ram_we", int'(ram_we), int'(w && in_xram(a) && m_on != 0));
    if (a < 32'h8000) exp_rd = int'(rom_rdata);
    else if (in_xram(a) && m_on != 0) exp_rd = int'(ram_rdata);
    else exp_rd = 32'hFF;
    chk("R10 cpu_rdata", int'(cpu_rdata), exp_rd);
  endtask

  task automatic cycle(input int a, input int d, input bit w);
    drive(a, d, w);
    check_all(a, w);
    commit(a, d, w);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state seen through the ports
    drive(32'h4000, 0, 0);
    chk("R1 rom bank 1", int'(rom_addr), 32'h4000);
    chk("R1 gate closed", int'(ram_on), 0);
    commit(32'h4000, 0, 0);
    drive(32'hA010, 0, 0);
    chk("R1 ram bank 0", int'(ram_addr), 32'h0010);
    chk("R1 closed read", int'(cpu_rdata), 32'hFF);
    commit(32'hA010, 0, 0);

    // R3: zero coerced to one, other low values taken
    cycle(32'h2000, 32'h00, 1);
    drive(32'h4ABC, 0, 0); chk("R3 zero->1", int'(rom_addr), 32'h4ABC); commit(32'h4ABC, 0, 0);
    cycle(32'h3FFF, 32'hE5, 1);
    drive(32'h4001, 0, 0); chk("R3 low=5", int'(rom_addr), 5 * 32'h4000 + 1); commit(32'h4001, 0, 0);

    // R5 then R3 keeping upper bits
    cycle(32'h4000, 32'h02, 1);
    drive(32'h4000, 0, 0); chk("R5 upper=2", int'(rom_addr), 32'h45 * 32'h4000); commit(32'h4000, 0, 0);
    cycle(32'h2000, 32'h20, 1);
    drive(32'h7FFF, 0, 0); chk("R3 upper kept", int'(rom_addr), 32'h41 * 32'h4000 + 32'h3FFF); commit(32'h7FFF, 0, 0);
    drive(32'hA000, 0, 0); chk("R5 ram bank kept", int'(ram_addr), 0); commit(32'hA000, 0, 0);

    // R6 / R4
    cycle(32'h6000, 32'hFF, 1);
    cycle(32'h5000, 32'h03, 1);
    drive(32'hA123, 0, 0); chk("R4 ram bank 3", int'(ram_addr), 32'h6123); commit(32'hA123, 0, 0);
    drive(32'h4000, 0, 0); chk("R4 rom kept", int'(rom_addr), 32'h41 * 32'h4000); commit(32'h4000, 0, 0);
    cycle(32'h8000, 32'h00, 1);
    cycle(32'h7000, 32'h00, 1);
    cycle(32'h4000, 32'h01, 1);
    drive(32'hA000, 0, 0); chk("R6 mode 0 keeps ram bank", int'(ram_addr), 32'h6000); commit(32'hA000, 0, 0);

    // R2 / R10
    cycle(32'h0000, 32'h3A, 1);
    drive(32'hA055, 32'h11, 1); chk("R10 we open", int'(ram_we), 1); chk("R2 open", int'(ram_on), 1);
    commit(32'hA055, 32'h11, 1);
    drive(32'hB000, 0, 0); chk("R10 pass", int'(cpu_rdata), int'(ram_rdata)); commit(32'hB000, 0, 0);
    cycle(32'h1000, 32'hAB, 1);
    drive(32'hA055, 32'h11, 1); chk("R10 we closed", int'(ram_we), 0); chk("R2 closed", int'(ram_on), 0);
    commit(32'hA055, 32'h11, 1);

    // R11: same-cycle write and translation
    m_mode = m_mode; // model already tracks mode 0
    drive(32'h4123, 32'h03, 1);
    chk("R11 old bank in write cycle", int'(rom_addr), exp_rom(32'h4123));
    commit(32'h4123, 32'h03, 1);
    drive(32'h4123, 0, 0);
    chk("R11 new bank next cycle", int'(rom_addr), 32'h61 * 32'h4000 + 32'h0123);
    commit(32'h4123, 0, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int a, d;
      bit w;
      a = ($urandom % 8) * 32'h2000 + ($urandom % 32'h2000);
      d = $urandom % 256;
      if ($urandom % 4 == 0) d = (d & 32'hF0) | 32'h0A;
      if ($urandom % 8 == 0) d = d & 32'hE0;
      w = ($urandom % 2) == 1;
      cycle(a, d, w);
    end

    summary();
  end
endmodule